// File: doc/BRIEF.md
# Synchronous Transmit RTS/CTS Sequencer

This block controls a bit-serial synchronous transmitter that uses request-to-send and clear-to-send handshaking. It reads frame bytes from a show-ahead transmit FIFO, in which a marker flags the final byte of each frame. It then drives a serial data line and an RTS line. All timing runs in one system clock domain. The falling edge of the transmit clock arrives as a one-cycle strobe, and the serial data and RTS change only on cycles that carry that strobe.

A frame opens with a programmable 8-bit pattern, sent MSB first, which may act as a flag, a sync word or a preamble. The payload bytes follow, also MSB first, and the same pattern closes the frame. RTS rises on the strobe that starts the frame. When CTS is already seen as asserted, the first pattern bit leaves on that same strobe, so there is no lead time.

RTS stays high for one strobe after the last closing bit. The CTS input can pass through a two-stage synchronizer or be used directly, and it can be forced asserted when the pin is used for other purposes.

The FSM has six states:

- IDLE: no frame is active.
- WAIT_CTS: RTS is high and the block waits for CTS.
- OPEN: the opening pattern is being sent.
- DATA: payload bytes are being sent.
- CLOSE: the closing pattern is being sent.
- TAIL: the one-strobe hold of RTS.

Transitions, all taken on a strobe:

- IDLE→OPEN when the FIFO has data and CTS is seen.
- IDLE→WAIT_CTS when the FIFO has data but CTS is not seen.
- WAIT_CTS→OPEN when CTS is seen.
- OPEN→DATA when the pattern completes and the FIFO has a byte.
- OPEN→OPEN as a fill when the pattern completes and the FIFO is empty.
- DATA→DATA when the next byte is taken, or a fill pattern is sent.
- DATA→CLOSE after the final byte.
- OPEN/DATA→CLOSE on loss of CTS, which is an abort.
- CLOSE→TAIL after the eighth closing bit.
- TAIL→IDLE.

Top module: `stx_rts_sequencer`

## Requirements
- R1: While no frame is active, `txd` is 1 and `rts` is 0, and strobes with an empty FIFO leave both unchanged.
- R2: `txd` and `rts` change only on a clock edge at which `tx_fall` was high.
- R3: `rts` rises only on a strobe while `fifo_valid` is 1. If CTS is seen on that strobe, the MSB of `flag_pattern` appears on `txd` at that same strobe (zero lead), in both `cts_direct` modes.
- R4: A frame is sent as `flag_pattern` (8 bits, MSB first), then each FIFO byte MSB first in FIFO order up to and including the byte with `fifo_last`=1, then `flag_pattern` again, all with `rts`=1.
- R5: `rts` falls on the strobe right after the last closing bit, and `txd` returns to 1 on that strobe.
- R6: If CTS is not seen when a frame starts, `rts` goes to 1 and `txd` stays 1 on every strobe until CTS is seen. The first pattern bit goes out on the first strobe at which CTS is seen. With `cts_direct`=0, `cts` passes through a two-stage synchronizer; with `cts_direct`=1 it is used as is.
- R7: With `cts_force`=1, CTS counts as asserted whatever the `cts` pin does.
- R8: If CTS is not seen on a strobe in OPEN or DATA, the bit in progress ends and the closing pattern begins on that strobe. `cts_lost` becomes 1 and stays 1 until the next frame sends its first bit.
- R9: If the FIFO is empty when a pattern or a non-final byte completes, the pattern is sent again as fill, and the next FIFO byte follows it.
- R10: A queued frame starts on the strobe right after the strobe on which `rts` fell, giving exactly one strobe with `rts`=0 between frames.
- R11: `fifo_pop` is a one-cycle pulse, only in a strobe cycle with `fifo_valid`=1. It occurs on the strobe that sends the eighth bit of the preceding pattern or byte, and the byte is taken from `fifo_data` in that cycle.
- R12: After reset, `txd`=1, `rts`=0 and `cts_lost`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_fall | input | 1 | One-cycle strobe marking a transmit-clock falling edge |
| fifo_valid | input | 1 | FIFO holds at least one byte |
| fifo_data | input | BYTE_W | Head byte of the FIFO (show-ahead) |
| fifo_last | input | 1 | Head byte is the final byte of its frame |
| fifo_pop | output | 1 | Removes the head byte from the FIFO |
| cts | input | 1 | Clear-to-send pin, active high |
| cts_direct | input | 1 | 1: use `cts` without the synchronizer |
| cts_force | input | 1 | 1: treat CTS as always asserted |
| flag_pattern | input | BYTE_W | Opening and closing pattern (typically 8'h7E) |
| txd | output | 1 | Serial data, MSB first |
| rts | output | 1 | Request-to-send, active high |
| cts_lost | output | 1 | Sticky flag: the last frame was cut short by loss of CTS |

## Verification
`txd`, `rts` and `cts_lost` are registered at the clock edge that ends a `tx_fall` cycle. The bench therefore raises the strobe on a falling clock edge and reads these outputs at the next falling edge, one register stage later. Each reading is logged as the value for that strobe.

`fifo_pop` is combinational within the strobe cycle, so the bench samples it shortly after raising `tx_fall` and before the capturing edge. In synchronized mode, a CTS change becomes visible two system clocks later. The bench waits three clocks after toggling `cts` before the next strobe, so that each waiting, abort and zero-lead result falls on a known strobe index.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CTS,
        ST_OPEN,
        ST_DATA,
        ST_CLOSE,
        ST_TAIL
    } stx_state_e;

    typedef enum logic [1:0] {
        SH_HOLD,
        SH_SHIFT,
        SH_RELOAD,
        SH_START
    } sh_op_e;

endpackage

// File: rtl/stx_cts_front.sv
module stx_cts_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_in,
    input  logic cts_direct,
    input  logic cts_force,
    output logic cts_ok
);
    logic [STAGES-1:0] pipe;
    logic              cts_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], cts_in};
        end
    end

    generate
        if (STAGES > 0) begin : g_sync_path
            always_comb begin
                cts_seen = cts_direct ? cts_in : pipe[STAGES-1];
            end
        end
    endgenerate

    always_comb begin
        cts_ok = cts_force | cts_seen;
    end

endmodule

// File: rtl/stx_bit_shifter.sv
module stx_bit_shifter
    import stx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sh_op_e       op,
    input  logic [W-1:0] load_val,
    output logic         bit_out,
    output logic         byte_end
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    // A START sends the new byte's MSB at once; every other op sends the held MSB.
    always_comb begin
        bit_out  = (op == SH_START) ? load_val[W-1] : sh[W-1];
        byte_end = (cnt == LAST_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else begin
            unique case (op)
                SH_HOLD: begin
                    sh  <= sh;
                    cnt <= cnt;
                end
                SH_SHIFT: begin
                    sh  <= sh << 1;
                    cnt <= byte_end ? '0 : cnt + CW'(1);
                end
                SH_RELOAD: begin
                    sh  <= load_val;
                    cnt <= '0;
                end
                SH_START: begin
                    sh  <= load_val << 1;
                    cnt <= CW'(1);
                end
                default: begin
                    sh  <= sh;
                    cnt <= cnt;
                end
            endcase
        end
    end

endmodule

// File: rtl/stx_rts_sequencer.sv
module stx_rts_sequencer
    import stx_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_fall,
    input  logic              fifo_valid,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_pop,
    input  logic              cts,
    input  logic              cts_direct,
    input  logic              cts_force,
    input  logic [BYTE_W-1:0] flag_pattern,
    output logic              txd,
    output logic              rts,
    output logic              cts_lost
);
    stx_state_e        st, st_nx;
    sh_op_e            op;
    logic [BYTE_W-1:0] load_val;
    logic              bit_out, byte_end, cts_ok;
    logic              last_q, last_nx;
    logic              txd_nx, rts_nx, lost_set, lost_clr;

    stx_cts_front #(.STAGES(SYNC_STAGES)) u_cts (
        .clk        (clk),
        .rst_n      (rst_n),
        .cts_in     (cts),
        .cts_direct (cts_direct),
        .cts_force  (cts_force),
        .cts_ok     (cts_ok)
    );

    stx_bit_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (load_val),
        .bit_out  (bit_out),
        .byte_end (byte_end)
    );

    // Next state, shifter control and next output values; all moves wait for a strobe.
    always_comb begin
        st_nx    = st;
        op       = SH_HOLD;
        load_val = flag_pattern;
        last_nx  = last_q;
        fifo_pop = 1'b0;
        txd_nx   = txd;
        rts_nx   = rts;
        lost_set = 1'b0;
        lost_clr = 1'b0;
        if (tx_fall) begin
            unique case (st)
                ST_IDLE: begin
                    txd_nx = 1'b1;
                    rts_nx = 1'b0;
                    if (fifo_valid) begin
                        rts_nx = 1'b1;
                        if (cts_ok) begin
                            op       = SH_START;
                            txd_nx   = bit_out;
                            lost_clr = 1'b1;
                            st_nx    = ST_OPEN;
                        end else begin
                            st_nx = ST_WAIT_CTS;
                        end
                    end
                end
                ST_WAIT_CTS: begin
                    if (cts_ok) begin
                        op       = SH_START;
                        txd_nx   = bit_out;
                        lost_clr = 1'b1;
                        st_nx    = ST_OPEN;
                    end
                end
                ST_OPEN, ST_DATA: begin
                    if (!cts_ok) begin
                        // Abort: closing pattern begins on this very strobe.
                        op       = SH_START;
                        txd_nx   = bit_out;
                        lost_set = 1'b1;
                        st_nx    = ST_CLOSE;
                    end else begin
                        txd_nx = bit_out;
                        if (!byte_end) begin
                            op = SH_SHIFT;
                        end else if (st == ST_DATA && last_q) begin
                            op    = SH_RELOAD;
                            st_nx = ST_CLOSE;
                        end else if (fifo_valid) begin
                            op       = SH_RELOAD;
                            load_val = fifo_data;
                            fifo_pop = 1'b1;
                            last_nx  = fifo_last;
                            st_nx    = ST_DATA;
                        end else begin
                            // Underrun: pattern repeated as fill.
                            op      = SH_RELOAD;
                            last_nx = 1'b0;
                        end
                    end
                end
                ST_CLOSE: begin
                    txd_nx = bit_out;
                    op     = SH_SHIFT;
                    if (byte_end) begin
                        st_nx = ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    txd_nx = 1'b1;
                    rts_nx = 1'b0;
                    st_nx  = ST_IDLE;
                end
                default: begin
                    st_nx = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            last_q <= 1'b0;
        end else begin
            st     <= st_nx;
            last_q <= last_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd      <= 1'b1;
            rts      <= 1'b0;
            cts_lost <= 1'b0;
        end else begin
            txd <= txd_nx;
            rts <= rts_nx;
            if (lost_set) begin
                cts_lost <= 1'b1;
            end else if (lost_clr) begin
                cts_lost <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/stx_rts_checker.sv
module stx_rts_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_fall,
    input logic fifo_valid,
    input logic fifo_pop,
    input logic txd,
    input logic rts,
    input logic cts_lost
);

    a_r2_change_on_strobe: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$past(tx_fall) |-> ($stable(txd) && $stable(rts))
    );

    a_r1_idle_line_high: assert property (
        @(posedge clk) disable iff (!rst_n)
        !rts |-> txd
    );

    a_r3_rts_rise_qualified: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(rts) |-> ($past(tx_fall) && $past(fifo_valid))
    );

    a_r11_pop_qualified: assert property (
        @(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (tx_fall && fifo_valid && rts)
    );

    a_r8_lost_inside_frame: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(cts_lost) |-> rts
    );

endmodule

bind stx_rts_sequencer stx_rts_checker u_stx_chk (.*);

// File: tb/test_stx_rts_sequencer.sv
module test_stx_rts_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_fall = 1'b0;
    logic       fifo_valid;
    logic [7:0] fifo_data;
    logic       fifo_last;
    logic       fifo_pop;
    logic       cts = 1'b0;
    logic       cts_direct = 1'b0;
    logic       cts_force = 1'b0;
    logic [7:0] flag_pattern = 8'h7E;
    logic       txd, rts, cts_lost;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    stx_rts_sequencer i_stx_rts_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_fall      (tx_fall),
        .fifo_valid   (fifo_valid),
        .fifo_data    (fifo_data),
        .fifo_last    (fifo_last),
        .fifo_pop     (fifo_pop),
        .cts          (cts),
        .cts_direct   (cts_direct),
        .cts_force    (cts_force),
        .flag_pattern (flag_pattern),
        .txd          (txd),
        .rts          (rts),
        .cts_lost     (cts_lost)
    );

    // Show-ahead FIFO model.
    logic [7:0] qd [0:31];
    logic       ql [0:31];
    logic [4:0] wr_p = '0;
    logic [4:0] rd_p;
    logic       flush = 1'b0;

    assign fifo_valid = (rd_p != wr_p);
    assign fifo_data  = qd[rd_p];
    assign fifo_last  = ql[rd_p];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_p <= '0;
        else if (flush)    rd_p <= wr_p;
        else if (fifo_pop) rd_p <= rd_p + 5'd1;
    end

    logic txd_log [0:127];
    logic rts_log [0:127];
    logic pop_log [0:127];
    logic exp_txd [0:127];
    logic exp_rts [0:127];
    int   log_n = 0;
    int   exp_n = 0;

    task automatic push(input logic [7:0] b, input logic l);
        qd[wr_p] = b;
        ql[wr_p] = l;
        wr_p     = wr_p + 5'd1;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // One strobe: raise at a falling edge, capture at the next falling edge.
    task automatic step();
        @(negedge clk);
        tx_fall = 1'b1;
        #1;
        pop_log[log_n] = fifo_pop;
        @(negedge clk);
        tx_fall = 1'b0;
        txd_log[log_n] = txd;
        rts_log[log_n] = rts;
        log_n++;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_logs();
        log_n = 0;
        exp_n = 0;
    endtask

    task automatic exp_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            exp_txd[exp_n] = b[i];
            exp_rts[exp_n] = 1'b1;
            exp_n++;
        end
    endtask

    task automatic exp_byte(input logic [7:0] b);
        exp_bits(b, 8);
    endtask

    task automatic exp_line(input logic t, input logic r);
        exp_txd[exp_n] = t;
        exp_rts[exp_n] = r;
        exp_n++;
    endtask

    task automatic check_val(input string req, input int got, input int expv);
        n_checks++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic check_stream(input string req);
        int first;
        int mism;
        first = -1;
        mism  = 0;
        n_checks++;
        for (int i = 0; i < exp_n; i++) begin
            if (i >= log_n || txd_log[i] !== exp_txd[i] || rts_log[i] !== exp_rts[i]) begin
                if (first < 0) first = i;
                mism++;
            end
        end
        if (log_n != exp_n) mism++;
        if (mism != 0) begin
            n_fail++;
            if (first < 0) first = 0;
            $display("FAIL %s: strobe %0d got txd=%b rts=%b expected txd=%b rts=%b (logged %0d, expected %0d)",
                     req, first, txd_log[first], rts_log[first],
                     exp_txd[first], exp_rts[first], log_n, exp_n);
        end
    endtask

    task automatic t_reset();
        check_val("R12 txd", int'(txd), 1);
        check_val("R12 rts", int'(rts), 0);
        check_val("R12 cts_lost", int'(cts_lost), 0);
        push(8'h11, 1'b1);
        repeat (6) @(negedge clk);
        check_val("R2 no strobe rts", int'(rts), 0);
        check_val("R2 no strobe txd", int'(txd), 1);
        do_flush();
    endtask

    task automatic t_idle();
        clear_logs();
        run(4);
        for (int i = 0; i < 4; i++) exp_line(1'b1, 1'b0);
        check_stream("R1 idle strobes");
    endtask

    task automatic t_frame_sync();
        int pops;
        clear_logs();
        cts_direct = 1'b0;
        cts = 1'b1;
        flag_pattern = 8'h7E;
        repeat (3) @(negedge clk);
        push(8'hA5, 1'b0);
        push(8'h3C, 1'b1);
        run(33);
        exp_byte(8'h7E); exp_byte(8'hA5); exp_byte(8'h3C); exp_byte(8'h7E);
        exp_line(1'b1, 1'b0);
        check_stream("R4 sync-mode frame");
        check_val("R3 zero lead rts", int'(rts_log[0]), 1);
        check_val("R3 zero lead bit", int'(txd_log[0]), 0);
        check_val("R5 rts held on last bit", int'(rts_log[31]), 1);
        check_val("R5 rts low one strobe later", int'(rts_log[32]), 0);
        pops = 0;
        for (int i = 0; i < 33; i++) pops += int'(pop_log[i]);
        check_val("R11 pop count", pops, 2);
        check_val("R11 pop on strobe 7", int'(pop_log[7]), 1);
        check_val("R11 pop on strobe 15", int'(pop_log[15]), 1);
    endtask

    task automatic t_frame_direct();
        clear_logs();
        cts_direct = 1'b1;
        flag_pattern = 8'hB4;
        push(8'h0F, 1'b1);
        run(25);
        exp_byte(8'hB4); exp_byte(8'h0F); exp_byte(8'hB4);
        exp_line(1'b1, 1'b0);
        check_stream("R4 direct-mode frame");
        check_val("R3 direct zero lead bit", int'(txd_log[0]), 1);
        check_val("R3 direct zero lead rts", int'(rts_log[0]), 1);
        check_val("R5 direct tail", int'(rts_log[24]), 0);
        flag_pattern = 8'h7E;
    endtask

    task automatic t_force();
        clear_logs();
        cts_direct = 1'b0;
        cts = 1'b0;
        cts_force = 1'b1;
        repeat (3) @(negedge clk);
        push(8'h66, 1'b1);
        run(25);
        exp_byte(8'h7E); exp_byte(8'h66); exp_byte(8'h7E);
        exp_line(1'b1, 1'b0);
        check_stream("R7 forced CTS frame");
        cts_force = 1'b0;
    endtask

    task automatic t_wait();
        clear_logs();
        cts_direct = 1'b0;
        cts = 1'b0;
        repeat (3) @(negedge clk);
        push(8'h99, 1'b1);
        run(3);
        check_val("R6 rts while waiting", int'(rts), 1);
        cts = 1'b1;
        repeat (3) @(negedge clk);
        run(25);
        for (int i = 0; i < 3; i++) exp_line(1'b1, 1'b1);
        exp_byte(8'h7E); exp_byte(8'h99); exp_byte(8'h7E);
        exp_line(1'b1, 1'b0);
        check_stream("R6 wait for CTS then frame");
    endtask

    task automatic t_abort();
        clear_logs();
        cts_direct = 1'b1;
        cts = 1'b1;
        push(8'h3C, 1'b0);
        push(8'hC3, 1'b1);
        run(11);
        cts = 1'b0;
        run(9);
        exp_byte(8'h7E); exp_bits(8'h3C, 3); exp_byte(8'h7E);
        exp_line(1'b1, 1'b0);
        check_stream("R8 abort closes frame");
        check_val("R8 cts_lost set", int'(cts_lost), 1);
        do_flush();
        cts = 1'b1;
        push(8'h55, 1'b1);
        step();
        check_val("R8 cts_lost cleared at next frame", int'(cts_lost), 0);
        run(24);
        clear_logs();
    endtask

    task automatic t_underrun();
        clear_logs();
        push(8'h5A, 1'b0);
        run(16);
        push(8'h81, 1'b1);
        run(25);
        exp_byte(8'h7E); exp_byte(8'h5A); exp_byte(8'h7E); exp_byte(8'h81);
        exp_byte(8'h7E);
        exp_line(1'b1, 1'b0);
        check_stream("R9 underrun fill");
    endtask

    task automatic t_back_to_back();
        clear_logs();
        push(8'h81, 1'b1);
        push(8'h18, 1'b1);
        run(50);
        exp_byte(8'h7E); exp_byte(8'h81); exp_byte(8'h7E);
        exp_line(1'b1, 1'b0);
        exp_byte(8'h7E); exp_byte(8'h18); exp_byte(8'h7E);
        exp_line(1'b1, 1'b0);
        check_stream("R10 back-to-back frames");
        check_val("R10 new frame right after gap", int'(rts_log[25]), 1);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_frame_sync();
        t_frame_direct();
        t_force();
        t_wait();
        t_abort();
        t_underrun();
        t_back_to_back();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule